// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This block is a bank of identical down-counting timer channels behind a small register interface. Each channel holds a reload value, a live count, a control word and a sticky expiry flag. An enabled channel counts down once per clock. When the count reaches zero, the channel reloads from its reload value, sets its flag and keeps counting. The channel's interrupt line is high while the flag is set and the channel's interrupt enable is on. So a channel with reload value L produces one expiry every L+1 clocks. A module-wide stop bit freezes every channel at once. It is set out of reset, so software must clear it before anything counts.

A running period can be cut short in only one way: clear the channel's enable and set it again. Changing the reload value while a count runs leaves the count alone, and the new value is used at the next expiry. Any channel other than the first can be cascaded onto its lower neighbour. It then steps once per expiry of that neighbour instead of once per clock, which builds a wider timer out of two channels.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every channel register reads 0, the module control word at offset 0x000 reads 0x2 (stop bit, bit 1, set) and all interrupt lines are low.
- R2: Address map: module control at 0x000. Channel n occupies 0x100+0x10*n, with reload value at +0x0, live count at +0x4, control at +0x8 and flag at +0xC. Reads of any other offset return 0, and writes to them change nothing.
- R3: Control bit 0 is the run enable, bit 1 the interrupt enable and bit 2 the cascade select. On the clock after the enable goes from 0 to 1, the count is loaded with the reload value.
- R4: A running channel decrements once per clock. On the clock where its count is 0, it reloads from the reload value and sets its flag (bit 0 of the flag register), so expiries are reload+1 clocks apart.
- R5: Writing the reload value while running does not change the live count. The new value is first used at the next reload.
- R6: While the run enable is 0, the count holds its value. Clearing and then setting the enable restarts the period from the current reload value.
- R7: While the stop bit (bit 1 at 0x000) is 1, no channel decrements or reloads. Loading the count on an enable rising edge still takes place.
- R8: Writing the flag register with bit 0 set clears the flag. Writing it with bit 0 clear has no effect.
- R9: If an expiry and a flag-clear write fall on the same clock, the flag ends up set.
- R10: Each interrupt line equals its channel's flag AND its interrupt enable.
- R11: A channel n>0 with the cascade bit set decrements once per expiry of channel n-1, in the same clock as that expiry. On channel 0 the cascade bit has no effect and reads back 0.
- R12: The live count register is read-only. Writes to it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W (12) | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one write per clock |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Read data for regAddr, combinational |
| irq | output | NUM_CH (4) | Per-channel level interrupt |

## Verification
Two events can land on the same clock edge: a software clear of a channel's flag, and that channel's own expiry. The bench follows the reference model's count for channel 0 until it sees 0 at a falling edge. It then issues the flag-clear write so that the write is captured on the edge where the reload happens. The flag must still read 1 and the interrupt must stay high. The same edge-alignment approach checks that a reload-value write landing on a running count changes nothing until the following reload.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
  // Write strobes issued by the decoder to a single channel datapath.
  typedef struct packed {
    logic ldWr;    // reload value write
    logic ctlWr;   // control word write
    logic flgClr;  // flag write with bit 0 set
  } chStrobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
`timescale 1ns/1ps
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic                             regWrEn,
  input  logic [1:0]                       wrLowBits,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     chLoad,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     chCount,
  input  logic [NUM_CH-1:0][2:0]           chCtl,
  input  logic [NUM_CH-1:0]                chFlag,
  output chStrobe_t [NUM_CH-1:0]           chStb,
  output logic                             modDis,
  output logic [DATA_W-1:0]                regRdData
);
  localparam int CH_BASE = 'h100;
  localparam int CH_SPAN = 16;
  localparam int CH_END  = CH_BASE + CH_SPAN * NUM_CH;
  localparam int IDX_W   = ADDR_W - 4;
  localparam logic [3:0] OFF_LOAD  = 4'h0;
  localparam logic [3:0] OFF_COUNT = 4'h4;
  localparam logic [3:0] OFF_CTL   = 4'h8;
  localparam logic [3:0] OFF_FLAG  = 4'hC;

  logic              modHit;
  logic              inChanSpace;
  logic [ADDR_W-1:0] relAddr;
  logic [IDX_W-1:0]  chIdx;
  logic [3:0]        regOff;
  logic [NUM_CH-1:0] chSel;
  logic [NUM_CH-1:0] chTouched;

  assign modHit      = (regAddr == '0);
  assign inChanSpace = (regAddr >= ADDR_W'(CH_BASE)) && (regAddr < ADDR_W'(CH_END));
  assign relAddr     = regAddr - ADDR_W'(CH_BASE);
  assign chIdx       = relAddr[ADDR_W-1:4];
  assign regOff      = relAddr[3:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gDecode
    assign chSel[g]        = inChanSpace && (chIdx == IDX_W'(g));
    assign chStb[g].ldWr   = regWrEn && chSel[g] && (regOff == OFF_LOAD);
    assign chStb[g].ctlWr  = regWrEn && chSel[g] && (regOff == OFF_CTL);
    assign chStb[g].flgClr = regWrEn && chSel[g] && (regOff == OFF_FLAG) && wrLowBits[0];
    assign chTouched[g]    = chStb[g].ldWr | chStb[g].ctlWr | chStb[g].flgClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 modDis <= 1'b1;
    else if (regWrEn && modHit) modDis <= wrLowBits[1];
  end

  always_comb begin
    regRdData = '0;
    if (modHit) regRdData[1] = modDis;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chSel[i]) begin
        case (regOff)
          OFF_LOAD:  regRdData = DATA_W'(chLoad[i]);
          OFF_COUNT: regRdData = DATA_W'(chCount[i]);
          OFF_CTL:   regRdData = DATA_W'(chCtl[i]);
          OFF_FLAG:  regRdData = DATA_W'(chFlag[i]);
          default:   regRdData = '0;
        endcase
      end
    end
  end

  // R2: a single bus write reaches at most one channel register
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chTouched));

  // R7: the stop bit follows bit 1 of a module control write
  assert_stop_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && modHit) |=> (modDis == $past(wrLowBits[1])));
endmodule

// File: rtl/tick_timer_chan.sv
`timescale 1ns/1ps
module tick_timer_chan
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter bit CAN_CHAIN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  chStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             modDis,
  input  logic             prevZero,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countVal,
  output logic [2:0]       ctlVal,
  output logic             flag,
  output logic             zeroEvt,
  output logic             irq
);
  logic [CNT_W-1:0] loadQ;
  logic [CNT_W-1:0] cntQ;
  logic             enQ;
  logic             ieQ;
  logic             chainQ;
  logic             armedQ;
  logic             flagQ;
  logic             chainOn;
  logic             tick;

  assign chainOn = CAN_CHAIN && chainQ;
  assign tick    = enQ && armedQ && !modDis && (chainOn ? prevZero : 1'b1);
  assign zeroEvt = tick && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ  <= '0;
      cntQ   <= '0;
      enQ    <= 1'b0;
      ieQ    <= 1'b0;
      chainQ <= 1'b0;
      armedQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      if (stb.ldWr) loadQ <= wrData;
      if (stb.ctlWr) begin
        enQ    <= wrData[0];
        ieQ    <= wrData[1];
        chainQ <= wrData[2];
      end
      armedQ <= enQ;
      if (enQ && !armedQ) cntQ <= loadQ;
      else if (tick)      cntQ <= zeroEvt ? loadQ : cntQ - 1'b1;
      if (zeroEvt)         flagQ <= 1'b1;
      else if (stb.flgClr) flagQ <= 1'b0;
    end
  end

  assign loadVal  = loadQ;
  assign countVal = cntQ;
  assign ctlVal   = {chainOn, ieQ, enQ};
  assign flag     = flagQ;
  assign irq      = flagQ && ieQ;

  // R3: first clock after enable rises loads the reload value
  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !armedQ) |=> (cntQ == $past(loadQ)));

  // R6: a disabled channel keeps its count
  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> $stable(cntQ));

  // R7: the stop bit freezes a channel that is already running
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modDis && armedQ) |=> $stable(cntQ));

  // R5: a reload value write does not disturb a running count
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldWr && enQ && armedQ && !tick) |=> $stable(cntQ));

  // R9: an expiry wins over a simultaneous flag clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |=> flagQ);
endmodule

// File: rtl/tick_timer_bank.sv
`timescale 1ns/1ps
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] irq
);
  chStrobe_t [NUM_CH-1:0]       chStb;
  logic                         modDis;
  logic [NUM_CH-1:0][CNT_W-1:0] chLoad;
  logic [NUM_CH-1:0][CNT_W-1:0] chCount;
  logic [NUM_CH-1:0][2:0]       chCtl;
  logic [NUM_CH-1:0]            chFlag;
  logic [NUM_CH-1:0]            chZero;
  logic [NUM_CH-1:0]            chPrev;

  tick_timer_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .wrLowBits(regWrData[1:0]), .chLoad(chLoad), .chCount(chCount),
    .chCtl(chCtl), .chFlag(chFlag), .chStb(chStb), .modDis(modDis),
    .regRdData(regRdData)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    if (g == 0) begin : gHead
      assign chPrev[g] = 1'b0;
    end else begin : gLink
      assign chPrev[g] = chZero[g-1];
    end
    tick_timer_chan #(.CNT_W(CNT_W), .CAN_CHAIN(g > 0)) uChan (
      .clk(clk), .rstN(rstN), .stb(chStb[g]), .wrData(regWrData[CNT_W-1:0]),
      .modDis(modDis), .prevZero(chPrev[g]), .loadVal(chLoad[g]),
      .countVal(chCount[g]), .ctlVal(chCtl[g]), .flag(chFlag[g]),
      .zeroEvt(chZero[g]), .irq(irq[g])
    );
  end
endmodule

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;

  tick_timer_bank uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  always #10ns clk = ~clk;

  // behavioural reference state
  logic [31:0] mLoad [NCH];
  logic [31:0] mCnt  [NCH];
  bit mEn [NCH], mIe [NCH], mChain [NCH], mArm [NCH], mFlag [NCH];
  bit mStop;
  logic [31:0] nCnt [NCH];
  bit nZero [NCH];

  function automatic logic [31:0] mRead(input logic [11:0] a);
    int ch;
    if (a == 12'h000) return {30'b0, mStop, 1'b0};
    if (a < 12'h100 || a >= 12'h140) return 32'h0;
    ch = (int'(a) - 'h100) / 16;
    case (a[3:0])
      4'h0: return mLoad[ch];
      4'h4: return mCnt[ch];
      4'h8: return {29'b0, mChain[ch], mIe[ch], mEn[ch]};
      4'hC: return {31'b0, mFlag[ch]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit pz, tk, clr;
    int ch;
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        mLoad[i] = 0; mCnt[i] = 0; mEn[i] = 0; mIe[i] = 0;
        mChain[i] = 0; mArm[i] = 0; mFlag[i] = 0;
      end
      mStop = 1;
    end else begin
      pz = 0;
      for (int i = 0; i < NCH; i++) begin
        tk = mEn[i] && mArm[i] && !mStop && ((i > 0 && mChain[i]) ? pz : 1'b1);
        nZero[i] = tk && (mCnt[i] == 0);
        if (mEn[i] && !mArm[i]) nCnt[i] = mLoad[i];
        else if (tk) nCnt[i] = nZero[i] ? mLoad[i] : mCnt[i] - 1;
        else nCnt[i] = mCnt[i];
        pz = nZero[i];
      end
      for (int i = 0; i < NCH; i++) begin
        clr = regWrEn && regAddr == 12'h10C + 12'(16 * i) && regWrData[0];
        mCnt[i] = nCnt[i];
        mArm[i] = mEn[i];
        if (nZero[i]) mFlag[i] = 1; else if (clr) mFlag[i] = 0;
      end
      if (regWrEn) begin
        if (regAddr == 12'h000) mStop = regWrData[1];
        else if (regAddr >= 12'h100 && regAddr < 12'h140) begin
          ch = (int'(regAddr) - 'h100) / 16;
          if (regAddr[3:0] == 4'h0) mLoad[ch] = regWrData;
          if (regAddr[3:0] == 4'h8) begin
            mEn[ch] = regWrData[0]; mIe[ch] = regWrData[1];
            mChain[ch] = (ch > 0) ? regWrData[2] : 1'b0;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every cycle: compare irq lines and current read data with the model
  always @(negedge clk) begin
    #2;
    if (rstN && cmpOn) begin
      chk("R10 irq vs model", {28'b0, irq},
          {28'b0, mFlag[3] & mIe[3], mFlag[2] & mIe[2], mFlag[1] & mIe[1], mFlag[0] & mIe[0]});
      chk("R4 read vs model", regRdData, mRead(regAddr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  logic [31:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1'b1;
    // R1 reset state
    rd(12'h000, 32'h2, "R1 module control");
    rd(12'h100, 32'h0, "R1 load");
    rd(12'h104, 32'h0, "R1 count");
    rd(12'h118, 32'h0, "R1 ctrl");
    rd(12'h13C, 32'h0, "R1 flag");
    chk("R1 irq", {28'b0, irq}, 32'h0);

    wr(12'h000, 32'h0);
    rd(12'h000, 32'h0, "R7 stop cleared");
    wr(12'h100, 32'd3);
    rd(12'h100, 32'd3, "R2 load readback");
    wr(12'h104, 32'h55);
    rd(12'h104, 32'h0, "R12 count read-only");

    // R3/R4 start and period
    wr(12'h108, 32'h3);
    @(negedge clk);
    rd(12'h104, 32'd3, "R3 start load");
    repeat (3) @(negedge clk);
    rd(12'h104, 32'd0, "R4 count at zero");
    rd(12'h10C, 32'd0, "R4 flag before expiry");
    @(negedge clk);
    rd(12'h104, 32'd3, "R4 reload");
    rd(12'h10C, 32'd1, "R4 flag set");
    chk("R10 irq raised", {31'b0, irq[0]}, 32'd1);

    // R5 reload write mid-period
    wr(12'h100, 32'd6);
    rd(12'h104, 32'd2, "R5 count undisturbed");
    repeat (3) @(negedge clk);
    rd(12'h104, 32'd6, "R5 new value at reload");

    // R8 flag write semantics
    wr(12'h10C, 32'h0);
    rd(12'h10C, 32'd1, "R8 write 0 ignored");
    wr(12'h10C, 32'h1);
    rd(12'h10C, 32'd0, "R8 write 1 clears");
    chk("R8 irq low after clear", {31'b0, irq[0]}, 32'd0);

    // R9 clear write on the expiry edge
    while (mCnt[0] != 0) @(negedge clk);
    wr(12'h10C, 32'h1);
    rd(12'h10C, 32'd1, "R9 set wins");

    // R10 interrupt enable off
    wr(12'h108, 32'h1);
    rd(12'h10C, 32'd1, "R10 flag still set");
    chk("R10 irq masked", {31'b0, irq[0]}, 32'd0);

    // R6 disable holds, re-enable restarts
    wr(12'h108, 32'h0);
    regAddr = 12'h104; #1; held = regRdData;
    repeat (3) @(negedge clk);
    rd(12'h104, held, "R6 hold while disabled");
    wr(12'h100, 32'd2);
    wr(12'h108, 32'h1);
    @(negedge clk);
    rd(12'h104, 32'd2, "R6 restart with reload value");

    // R7 stop bit freezes counting
    wr(12'h000, 32'h2);
    regAddr = 12'h104; #1; held = regRdData;
    repeat (5) @(negedge clk);
    rd(12'h104, held, "R7 frozen");
    wr(12'h000, 32'h0);

    // R11 cascade of channel 1 on channel 0
    wr(12'h108, 32'h0);
    wr(12'h10C, 32'h1);
    wr(12'h100, 32'd1);
    wr(12'h110, 32'd2);
    wr(12'h118, 32'h7);
    wr(12'h108, 32'h1);
    @(negedge clk);
    rd(12'h114, 32'd2, "R11 cascade start");
    repeat (2) @(negedge clk);
    rd(12'h114, 32'd1, "R11 step on lower expiry");
    repeat (4) @(negedge clk);
    rd(12'h114, 32'd2, "R11 cascade reload");
    rd(12'h11C, 32'd1, "R11 cascade flag");
    chk("R11 cascade irq", {31'b0, irq[1]}, 32'd1);
    wr(12'h108, 32'h5);
    rd(12'h108, 32'h1, "R11 chain bit ignored on channel 0");

    // R2 unmapped offsets
    rd(12'h004, 32'h0, "R2 unmapped 0x004");
    rd(12'h0FC, 32'h0, "R2 unmapped 0x0FC");
    rd(12'h102, 32'h0, "R2 unmapped 0x102");
    wr(12'h140, 32'hFFFF_FFFF);
    rd(12'h140, 32'h0, "R2 beyond last channel");

    // more patterns: channels 2 and 3, 3 cascaded
    wr(12'h120, 32'd5);
    wr(12'h130, 32'd1);
    wr(12'h138, 32'h7);
    wr(12'h128, 32'h3);
    regAddr = 12'h134;
    repeat (60) @(negedge clk);
    wr(12'h120, 32'd0);
    regAddr = 12'h124;
    repeat (40) @(negedge clk);
    regAddr = 12'h13C;
    repeat (40) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4ms;
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule